// File: doc/BRIEF.md
# Tri-State Pulse-Width Word Encoder

This block turns a parallel word of symbols into a continuous serial waveform on one output. The leading positions of the word are address symbols, each of which can take one of three values: zero, one or open. The remaining positions are binary data bits. Every symbol is sent as two pulses of equal period, and the mix of short and long high times in the pair selects the value. After the last symbol the line stays low for a fixed sync gap. The inputs are then sampled again and the next word starts.

The block has no start request. Once reset is released it sends word after word until reset is asserted again. A clock-enable input (`tick`) sets the length of one time unit, so one symbol lasts eight enabled cycles. The address and data counts are parameters. This covers a twelve-trit address with no data (3^12 = 531,441 codes), ten trits plus eight data bits, and eight trits plus four data bits.

Top module: `trit_pulse_encoder`

## Requirements
- R1: While `rst_n` is low, `wave_out` is 0. After release it stays 0 until the first cycle with `tick` high. That tick samples `sym_in` and starts a word, and `wave_out` goes to 1.
- R2: An address symbol with input code 2'b00 (zero) is sent as two short pulses. A short pulse is 1 time unit high followed by 3 units low.
- R3: An address symbol with input code 2'b01 (one) is sent as two long pulses. A long pulse is 3 units high followed by 1 unit low.
- R4: An address symbol with input code 2'b10 or 2'b11 (open) is sent as a long pulse followed by a short pulse.
- R5: Symbol positions at index N_ADDR and above are data bits. Code 2'b00 is sent as a zero (short, short) and every other code is sent as a one (long, long).
- R6: Symbols are sent in index order. Symbol 0 is taken from `sym_in[1:0]` and goes first, and symbol k takes `sym_in[2k+1:2k]`. Each symbol lasts exactly 8 time units.
- R7: After the last symbol, `wave_out` is low for 32 time units. The next tick then samples `sym_in` again and starts a new word. This repeats without end.
- R8: `sym_in` is sampled only on the tick that starts a word. Changes at any other time have no effect on the word being sent.
- R9: `wave_out` changes only on clock edges where `tick` is high. One time unit equals one enabled cycle.
- R10: Asserting `rst_n` low in the middle of a word stops it at once. After release, the next tick starts a fresh word from symbol 0 with newly sampled inputs.
- R11: The parameters N_ADDR and N_DATA set the address and data counts. The configurations (10, 8), (8, 4) and (12, 0) all behave as R2 to R7 describe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Time-unit enable: one enabled cycle is one unit |
| sym_in | input | 2*(N_ADDR+N_DATA) | Two bits per symbol, symbol k at bits [2k+1:2k] |
| wave_out | output | 1 | Serial pulse-width-coded waveform |

## Verification
The hardest case to reach from the ports is an input change that lands right after the sampling tick of a word. The same is true of a reset that cuts a word short. In both cases a wrong sampling instant or a stale symbol store would still yield a plausible waveform. The stimulus follows the word position on its own. It changes `sym_in` on the cycle just after a word starts and holds the new value through the whole word, and it also drops reset in the middle of a symbol. Around these directed cases, random tick gaps and random input changes run over many words at three parameter settings at once.

// File: rtl/tpe_pkg.sv
package tpe_pkg;

    typedef enum logic [1:0] {
        SYM_ZERO = 2'b00,
        SYM_ONE  = 2'b01,
        SYM_OPEN = 2'b10
    } sym_e;

    typedef enum logic [1:0] {
        ST_LOAD = 2'b00,
        ST_SEND = 2'b01,
        ST_SYNC = 2'b10
    } seq_st_e;

    // Address position: three-valued, both upper codes mean open
    function automatic logic [1:0] norm_addr(input logic [1:0] raw);
        logic [1:0] r;
        case (raw)
            2'b00:   r = SYM_ZERO;
            2'b01:   r = SYM_ONE;
            default: r = SYM_OPEN;
        endcase
        return r;
    endfunction

    // Data position: binary only, anything but zero counts as one
    function automatic logic [1:0] norm_data(input logic [1:0] raw);
        logic [1:0] r;
        if (raw == 2'b00) r = SYM_ZERO;
        else              r = SYM_ONE;
        return r;
    endfunction

endpackage

// File: rtl/tpe_capture.sv
module tpe_capture #(
    parameter int N_ADDR = 10,
    parameter int N_SYM  = 18
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [2*N_SYM-1:0]   raw,
    output logic [2*N_SYM-1:0]   codes_next
);
    import tpe_pkg::*;

    typedef struct packed {
        logic [2*N_SYM-1:0] codes;
    } cap_t;

    cap_t               cap_d, cap_q;
    logic [2*N_SYM-1:0] norm;

    generate
        for (genvar i = 0; i < N_SYM; i++) begin : g_norm
            if (i < N_ADDR) begin : g_addr
                assign norm[2*i +: 2] = norm_addr(raw[2*i +: 2]);
            end else begin : g_data
                assign norm[2*i +: 2] = norm_data(raw[2*i +: 2]);
            end
        end
    endgenerate

    always_comb begin
        cap_d = cap_q;
        if (load) begin
            cap_d.codes = norm;
        end
    end

    assign codes_next = cap_d.codes;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    AST_CODES_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(cap_q.codes)); // R8

    generate
        for (genvar j = N_ADDR; j < N_SYM; j++) begin : g_chk_data
            AST_DATA_NO_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
                cap_q.codes[2*j+1] == 1'b0); // R5
        end
    endgenerate

endmodule

// File: rtl/tpe_sequencer.sv
module tpe_sequencer #(
    parameter int N_SYM       = 18,
    parameter int PULSE_UNITS = 4,
    parameter int SYNC_UNITS  = 32,
    localparam int SYM_W  = (N_SYM > 1) ? $clog2(N_SYM) : 1,
    localparam int UNIT_W = (PULSE_UNITS > 1) ? $clog2(PULSE_UNITS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    output logic                 load,
    output tpe_pkg::seq_st_e     st_next,
    output tpe_pkg::seq_st_e     st_cur,
    output logic [SYM_W-1:0]     sym_next,
    output logic                 half_next,
    output logic [UNIT_W-1:0]    unit_next,
    output logic [UNIT_W-1:0]    unit_cur
);
    import tpe_pkg::*;

    localparam int GAP_W = (SYNC_UNITS > 1) ? $clog2(SYNC_UNITS) : 1;
    localparam logic [UNIT_W-1:0] UNIT_LAST = UNIT_W'(PULSE_UNITS - 1);
    localparam logic [SYM_W-1:0]  SYM_LAST  = SYM_W'(N_SYM - 1);
    localparam logic [GAP_W-1:0]  GAP_LAST  = GAP_W'(SYNC_UNITS - 1);

    typedef struct packed {
        seq_st_e           st;
        logic [UNIT_W-1:0] unit;
        logic              half;
        logic [SYM_W-1:0]  sym;
        logic [GAP_W-1:0]  gap;
    } seq_t;

    seq_t seq_d, seq_q;
    logic load_d;

    always_comb begin
        seq_d  = seq_q;
        load_d = 1'b0;
        if (tick) begin
            case (seq_q.st)
                ST_SEND: begin
                    if (seq_q.unit != UNIT_LAST) begin
                        seq_d.unit = seq_q.unit + 1'b1;
                    end else begin
                        seq_d.unit = '0;
                        if (!seq_q.half) begin
                            seq_d.half = 1'b1;
                        end else begin
                            seq_d.half = 1'b0;
                            if (seq_q.sym == SYM_LAST) begin
                                seq_d.st  = ST_SYNC;
                                seq_d.gap = '0;
                                seq_d.sym = '0;
                            end else begin
                                seq_d.sym = seq_q.sym + 1'b1;
                            end
                        end
                    end
                end
                ST_SYNC: begin
                    if (seq_q.gap == GAP_LAST) begin
                        load_d     = 1'b1;
                        seq_d.st   = ST_SEND;
                        seq_d.unit = '0;
                        seq_d.half = 1'b0;
                        seq_d.sym  = '0;
                        seq_d.gap  = '0;
                    end else begin
                        seq_d.gap = seq_q.gap + 1'b1;
                    end
                end
                default: begin
                    load_d     = 1'b1;
                    seq_d.st   = ST_SEND;
                    seq_d.unit = '0;
                    seq_d.half = 1'b0;
                    seq_d.sym  = '0;
                    seq_d.gap  = '0;
                end
            endcase
        end
    end

    assign load      = load_d;
    assign st_next   = seq_d.st;
    assign st_cur    = seq_q.st;
    assign sym_next  = seq_d.sym;
    assign half_next = seq_d.half;
    assign unit_next = seq_d.unit;
    assign unit_cur  = seq_q.unit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: ST_LOAD, unit: '0, half: 1'b0, sym: '0, gap: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    AST_SYM_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.sym <= SYM_LAST); // R6

    AST_NO_LOAD_STATE_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st != ST_LOAD) |=> (seq_q.st != ST_LOAD)); // R7

    AST_SEQ_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(seq_q)); // R9

endmodule

// File: rtl/tpe_pulse_shaper.sv
module tpe_pulse_shaper #(
    parameter int N_SYM    = 18,
    parameter int SYM_W    = 5,
    parameter int UNIT_W   = 2,
    parameter int SHORT_HI = 1,
    parameter int LONG_HI  = 3
) (
    input  logic [2*N_SYM-1:0]  codes,
    input  tpe_pkg::seq_st_e    st,
    input  logic [SYM_W-1:0]    sym,
    input  logic                half,
    input  logic [UNIT_W-1:0]   unit,
    output logic                level
);
    import tpe_pkg::*;

    localparam logic [UNIT_W:0] THR_SHORT = (UNIT_W+1)'(SHORT_HI);
    localparam logic [UNIT_W:0] THR_LONG  = (UNIT_W+1)'(LONG_HI);

    logic [1:0]      code;
    logic [UNIT_W:0] thr;

    always_comb begin
        code = SYM_ZERO;
        for (int i = 0; i < N_SYM; i++) begin
            if (sym == SYM_W'(i)) begin
                code = codes[2*i +: 2];
            end
        end
    end

    always_comb begin
        case (code)
            SYM_ZERO: thr = THR_SHORT;
            SYM_ONE:  thr = THR_LONG;
            default:  thr = half ? THR_SHORT : THR_LONG;
        endcase
    end

    assign level = (st == ST_SEND) && ({1'b0, unit} < thr);

endmodule

// File: rtl/trit_pulse_encoder.sv
module trit_pulse_encoder #(
    parameter int N_ADDR      = 10,
    parameter int N_DATA      = 8,
    parameter int PULSE_UNITS = 4,
    parameter int SHORT_HI    = 1,
    parameter int LONG_HI     = 3,
    parameter int SYNC_UNITS  = 32
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           tick,
    input  logic [2*(N_ADDR+N_DATA)-1:0]   sym_in,
    output logic                           wave_out
);
    import tpe_pkg::*;

    localparam int N_SYM  = N_ADDR + N_DATA;
    localparam int SYM_W  = (N_SYM > 1) ? $clog2(N_SYM) : 1;
    localparam int UNIT_W = (PULSE_UNITS > 1) ? $clog2(PULSE_UNITS) : 1;
    localparam logic [UNIT_W-1:0] UNIT_LAST = UNIT_W'(PULSE_UNITS - 1);

    typedef struct packed {
        logic wave;
    } out_t;

    logic               load;
    seq_st_e            st_next, st_cur;
    logic [SYM_W-1:0]   sym_next;
    logic               half_next;
    logic [UNIT_W-1:0]  unit_next, unit_cur;
    logic [2*N_SYM-1:0] codes_next;
    logic               level;
    out_t               out_d, out_q;

    tpe_sequencer #(
        .N_SYM       (N_SYM),
        .PULSE_UNITS (PULSE_UNITS),
        .SYNC_UNITS  (SYNC_UNITS)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .load      (load),
        .st_next   (st_next),
        .st_cur    (st_cur),
        .sym_next  (sym_next),
        .half_next (half_next),
        .unit_next (unit_next),
        .unit_cur  (unit_cur)
    );

    tpe_capture #(
        .N_ADDR (N_ADDR),
        .N_SYM  (N_SYM)
    ) u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .raw        (sym_in),
        .codes_next (codes_next)
    );

    tpe_pulse_shaper #(
        .N_SYM    (N_SYM),
        .SYM_W    (SYM_W),
        .UNIT_W   (UNIT_W),
        .SHORT_HI (SHORT_HI),
        .LONG_HI  (LONG_HI)
    ) u_shape (
        .codes (codes_next),
        .st    (st_next),
        .sym   (sym_next),
        .half  (half_next),
        .unit  (unit_next),
        .level (level)
    );

    always_comb begin
        out_d = out_q;
        if (tick) begin
            out_d.wave = level;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign wave_out = out_q.wave;

    AST_SYNC_GAP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (st_cur != ST_SEND) |-> !wave_out); // R7

    AST_PULSE_LEADS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (st_cur == ST_SEND && unit_cur == '0) |-> wave_out); // R2

    AST_PULSE_TAILS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (st_cur == ST_SEND && unit_cur == UNIT_LAST) |-> !wave_out); // R3

    AST_WORD_STARTS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> wave_out); // R1

    AST_OUT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(wave_out)); // R9

endmodule

// File: tb/sim_trit_pulse_encoder.sv
module sim_trit_pulse_encoder;

    localparam int CLK_PERIOD = 10;
    localparam int NINST = 3;
    localparam int NADD [NINST] = '{10, 8, 12};
    localparam int NSYM [NINST] = '{18, 12, 12};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [35:0] sym_in = '0;
    logic        o0, o1, o2;

    int          checks = 0;
    int          errors = 0;
    int          pos [NINST];
    logic [35:0] cap [NINST];
    string       override = "";

    always #(CLK_PERIOD/2) clk = ~clk;

    trit_pulse_encoder u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .sym_in(sym_in), .wave_out(o0));

    trit_pulse_encoder #(.N_ADDR(8), .N_DATA(4)) u1 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .sym_in(sym_in[23:0]), .wave_out(o1));

    trit_pulse_encoder #(.N_ADDR(12), .N_DATA(0)) u2 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .sym_in(sym_in[23:0]), .wave_out(o2));

    function automatic logic get_out(int i);
        if (i == 0) return o0;
        if (i == 1) return o1;
        return o2;
    endfunction

    function automatic logic exp_level(logic [35:0] c, int na, int ns, int p);
        int s, h, u;
        logic [1:0] cd;
        bit lng;
        if (p < 0 || p >= 8*ns) return 1'b0;
        s  = p / 8;
        h  = (p % 8) / 4;
        u  = p % 4;
        cd = c[2*s +: 2];
        if (s >= na)        lng = (cd != 2'b00);
        else if (cd == 2'b00) lng = 1'b0;
        else if (cd == 2'b01) lng = 1'b1;
        else                lng = (h == 0);
        return lng ? (u < 3) : (u < 1);
    endfunction

    function automatic string auto_tag(int i);
        int s;
        logic [1:0] cd;
        if (pos[i] < 0) return "R1";
        if (pos[i] >= 8*NSYM[i]) return "R7";
        s  = pos[i] / 8;
        cd = cap[i][2*s +: 2];
        if (s >= NADD[i]) return "R5";
        if (cd == 2'b00) return "R2";
        if (cd == 2'b01) return "R3";
        return "R4";
    endfunction

    task automatic chk(logic act, logic exp, string tag, int inst);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s inst %0d pos %0d actual %0b expected %0b",
                     tag, inst, pos[inst], act, exp);
        end
    endtask

    // One clock cycle: drive tick at a falling edge, compare at the next falling edge
    task automatic step(bit t);
        tick = t;
        @(negedge clk);
        for (int i = 0; i < NINST; i++) begin
            string tag;
            if (!rst_n) begin
                pos[i] = -1;
            end else if (t) begin
                if (pos[i] < 0 || pos[i] == 8*NSYM[i] + 31) pos[i] = 0;
                else pos[i] = pos[i] + 1;
                if (pos[i] == 0) cap[i] = sym_in;
            end
            if (override != "")  tag = override;
            else if (!t)         tag = "R9";
            else                 tag = auto_tag(i);
            if (i != 0) tag = {"R11 ", tag};
            chk(get_out(i), exp_level(cap[i], NADD[i], NSYM[i], pos[i]), tag, i);
        end
    endtask

    function automatic bit rnd_tick();
        return ($urandom % 4) != 0;
    endfunction

    function automatic logic [35:0] rnd_in();
        return {$urandom, $urandom};
    endfunction

    // Run until instance 0 has just started a new word
    task automatic to_word_start();
        bit t;
        do begin
            t = rnd_tick();
            step(t);
        end while (!(t && pos[0] == 0));
    endtask

    task automatic run_word_u0();
        bit t;
        do begin
            t = rnd_tick();
            step(t);
        end while (!(t && pos[0] == 8*NSYM[0] + 31));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < NINST; i++) begin
            pos[i] = -1;
            cap[i] = '0;
        end
        @(negedge clk);

        // R1: reset state and first word start
        override = "R1";
        step(1'b1);
        step(1'b1);
        rst_n = 1'b1;
        step(1'b0);
        step(1'b0);
        sym_in = '0;
        step(1'b1);
        override = "";

        // R2: all-zero word
        run_word_u0();

        // R3: all-one word
        sym_in = {18{2'b01}};
        to_word_start();
        run_word_u0();

        // R4: open coded as 2'b10, then 2'b11 (data positions become ones, R5)
        sym_in = {18{2'b10}};
        to_word_start();
        run_word_u0();
        sym_in = {18{2'b11}};
        to_word_start();
        run_word_u0();

        // R6: order, distinct symbols per position
        sym_in = 36'h1_B2E_4D8;
        to_word_start();
        override = "R6";
        run_word_u0();
        override = "";

        // R8: inputs change right after the sampling tick
        sym_in = 36'h5_5555_5555;
        to_word_start();
        sym_in = ~sym_in;
        override = "R8";
        run_word_u0();
        override = "";

        // R10: reset in the middle of a symbol
        to_word_start();
        for (int k = 0; k < 37; k++) step(1'b1);
        rst_n = 1'b0;
        override = "R10";
        step(1'b1);
        rst_n = 1'b1;
        sym_in = rnd_in();
        for (int k = 0; k < 20; k++) step(rnd_tick());
        override = "";

        // Random stimulus, inputs may change at any cycle
        for (int k = 0; k < 6000; k++) begin
            if (($urandom % 8) == 0) sym_in = rnd_in();
            step(rnd_tick());
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule